// File: doc/BRIEF.md
# SMBASE Window Lock Register

This block holds the firmware-facing control for a protected RAM window near the SMBASE area. It has an 8-bit lock register that firmware first probes with a query write. The probe reveals that the window feature exists and opens the lock bit for writing. A later write of the lock bit closes the window for good. From then on, accesses from outside system-management mode that fall in the window are swallowed: reads return all ones and writes are dropped. Accesses from system-management mode are routed to RAM.

A 16-bit extended protected-segment size register sits beside it and follows the same probe idea. Writing the all-ones query code replaces the value with the build-time size in MiB. A strap input turns the window feature off. In that mode the lock register is plain storage and the window stays open.

The block answers window lookups with two registered flags, `bh_o` and `ram_o`. The fabric that acts on these flags is outside the block.

Top module: `smbase_guard`

## Requirements
- R1: After reset `smbase_o` reads 0x00, `tseg_mb_o` reads 0xFFFF (query code, since the configured size is nonzero), and `lock_o`, `bh_o` and `ram_o` are 0.
- R2: With the feature on and no query done yet, a write to the lock register (`wr_sel_i`=0, value in `wr_data_i[7:0]`) of any value other than 0xFF is discarded. The register reads 0x00 and `lock_o` stays 0, even if bit 1 was set.
- R3: With the feature on, writing 0xFF in the unqueried state makes the register read 0x01 one edge later. From then on only bit 1 is writable, so writes with bit 1 clear leave 0x01.
- R4: After the query, a write with bit 1 set makes the register read exactly 0x02 and raises `lock_o` one edge later.
- R5: Once `lock_o` is 1, it and the register value 0x02 hold against every later write until reset.
- R6: With `smbase_en_i` low, the lock register stores the written byte as it is, `lock_o` never rises, and window accesses raise neither flag.
- R7: A valid access with an address in [0x30000, 0x4FFFF] raises `bh_o` (non-SMM) or `ram_o` (`acc_smm_i`=1) one edge later, only if `lock_o` was 1 at the sampling edge. Out-of-range, invalid or unlocked accesses raise neither. The two flags are never both 1.
- R8: Writing 0xFFFF to the size register (`wr_sel_i`=1) loads the configured size (16 MiB by default, 0x0010). Any other value is stored as written.
- R9: A write reaches only the register chosen by `wr_sel_i`. The other register and `lock_o` keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| smbase_en_i | input | 1 | Strap: window lock feature present |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 1 | 0 = lock register, 1 = size register |
| wr_data_i | input | 16 | Write data (lock register uses bits 7:0) |
| acc_valid_i | input | 1 | Memory access lookup valid |
| acc_addr_i | input | 32 | Memory access address |
| acc_smm_i | input | 1 | Access comes from system-management mode |
| smbase_o | output | 8 | Lock register value |
| tseg_mb_o | output | 16 | Size register value |
| lock_o | output | 1 | Window locked (registered) |
| bh_o | output | 1 | Access swallowed (registered) |
| ram_o | output | 1 | Access routed to RAM (registered) |

## Verification
Every result of this block is due exactly one rising edge after its stimulus: register values, the lock flag and the two window flags. The window flags use the lock state that was in force at that same edge. The driver applies one stimulus per cycle on the falling edge and queues the values due after the next rising edge. The monitor samples 1 ns after each rising edge and compares one queued item per cycle. A write and a lookup are never placed in the same cycle, so each expected flag depends on a lock state that is already settled.

// File: rtl/smbase_guard_pkg.sv
package smbase_guard_pkg;
  localparam int unsigned SMB_W     = 8;
  localparam int unsigned TSEG_W    = 16;
  localparam int unsigned LOCK_IDX  = 1;
  localparam logic [SMB_W-1:0]  SMB_QUERY  = 8'hFF;
  localparam logic [SMB_W-1:0]  SMB_IN_RAM = 8'h01;
  localparam logic [TSEG_W-1:0] TSEG_QUERY = 16'hFFFF;

  typedef enum logic {
    SEL_SMB  = 1'b0,
    SEL_TSEG = 1'b1
  } reg_sel_e;
endpackage

// File: rtl/smbase_lock_reg.sv
module smbase_lock_reg #(
  parameter int unsigned       W        = 8,
  parameter int unsigned       LOCK_IDX = 1,
  parameter logic [W-1:0]      QUERY    = '1,
  parameter logic [W-1:0]      IN_RAM   = 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         feat_en_i,
  input  logic         wr_i,
  input  logic [W-1:0] wd_i,
  output logic [W-1:0] val_o,
  output logic         lock_o
);
  localparam logic [W-1:0] LOCK_MASK = {{(W-1){1'b0}}, 1'b1} << LOCK_IDX;

  logic [W-1:0] val_q, val_d, mask_q, mask_d, merged;
  logic         lock_q, lock_d;

  assign merged = (val_q & ~mask_q) | (wd_i & mask_q);

  always_comb begin
    val_d  = val_q;
    mask_d = mask_q;
    lock_d = lock_q;
    if (wr_i) begin
      if (!feat_en_i) begin
        val_d  = merged;
        lock_d = 1'b0;
      end else if (merged == QUERY) begin
        val_d  = IN_RAM;
        mask_d = LOCK_MASK;
      end else begin
        // unqueried state: mask still all ones, drop the value
        val_d = (mask_q == '1) ? '0 : merged;
        if (val_d[LOCK_IDX]) begin
          mask_d = mask_q & ~LOCK_MASK;
          val_d  = LOCK_MASK;
          lock_d = 1'b1;
        end else begin
          lock_d = 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      val_q  <= '0;
      mask_q <= '1;
      lock_q <= 1'b0;
    end else begin
      val_q  <= val_d;
      mask_q <= mask_d;
      lock_q <= lock_d;
    end
  end

  assign val_o  = val_q;
  assign lock_o = lock_q;
endmodule

// File: rtl/smbase_tseg_reg.sv
module smbase_tseg_reg #(
  parameter int unsigned  W     = 16,
  parameter logic [W-1:0] QUERY = '1,
  parameter int unsigned  SIZE  = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_i,
  input  logic [W-1:0] wd_i,
  output logic [W-1:0] val_o
);
  localparam logic [W-1:0] SIZE_V  = W'(SIZE);
  localparam logic [W-1:0] RST_VAL = (SIZE != 0) ? QUERY : '0;

  logic [W-1:0] val_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      val_q <= RST_VAL;
    end else if (wr_i) begin
      val_q <= ((SIZE != 0) && (wd_i == QUERY)) ? SIZE_V : wd_i;
    end
  end

  assign val_o = val_q;
endmodule

// File: rtl/smbase_win_dec.sv
module smbase_win_dec #(
  parameter int unsigned       ADDR_W = 32,
  parameter logic [ADDR_W-1:0] BASE   = 32'h0003_0000,
  parameter logic [ADDR_W-1:0] SIZE   = 32'h0002_0000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              smm_i,
  input  logic              lock_i,
  output logic              bh_o,
  output logic              ram_o
);
  localparam logic [ADDR_W:0] LIMIT = {1'b0, BASE} + {1'b0, SIZE};

  logic hit;
  assign hit = valid_i && (addr_i >= BASE) && ({1'b0, addr_i} < LIMIT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bh_o  <= 1'b0;
      ram_o <= 1'b0;
    end else begin
      bh_o  <= hit && lock_i && !smm_i;
      ram_o <= hit && lock_i && smm_i;
    end
  end
endmodule

// File: rtl/smbase_guard.sv
module smbase_guard
  import smbase_guard_pkg::*;
#(
  parameter int unsigned       ADDR_W      = 32,
  parameter logic [ADDR_W-1:0] WIN_BASE    = 32'h0003_0000,
  parameter logic [ADDR_W-1:0] WIN_SIZE    = 32'h0002_0000,
  parameter int unsigned       EXT_TSEG_MB = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              smbase_en_i,
  input  logic              wr_en_i,
  input  logic              wr_sel_i,
  input  logic [TSEG_W-1:0] wr_data_i,
  input  logic              acc_valid_i,
  input  logic [ADDR_W-1:0] acc_addr_i,
  input  logic              acc_smm_i,
  output logic [SMB_W-1:0]  smbase_o,
  output logic [TSEG_W-1:0] tseg_mb_o,
  output logic              lock_o,
  output logic              bh_o,
  output logic              ram_o
);
  reg_sel_e sel;
  logic     wr_smb, wr_tseg;

  assign sel     = reg_sel_e'(wr_sel_i);
  assign wr_smb  = wr_en_i && (sel == SEL_SMB);
  assign wr_tseg = wr_en_i && (sel == SEL_TSEG);

  smbase_lock_reg #(
    .W(SMB_W), .LOCK_IDX(LOCK_IDX), .QUERY(SMB_QUERY), .IN_RAM(SMB_IN_RAM)
  ) u_lock (
    .clk_i, .rst_ni,
    .feat_en_i(smbase_en_i),
    .wr_i     (wr_smb),
    .wd_i     (wr_data_i[SMB_W-1:0]),
    .val_o    (smbase_o),
    .lock_o   (lock_o)
  );

  smbase_tseg_reg #(
    .W(TSEG_W), .QUERY(TSEG_QUERY), .SIZE(EXT_TSEG_MB)
  ) u_tseg (
    .clk_i, .rst_ni,
    .wr_i (wr_tseg),
    .wd_i (wr_data_i),
    .val_o(tseg_mb_o)
  );

  smbase_win_dec #(
    .ADDR_W(ADDR_W), .BASE(WIN_BASE), .SIZE(WIN_SIZE)
  ) u_win (
    .clk_i, .rst_ni,
    .valid_i(acc_valid_i),
    .addr_i (acc_addr_i),
    .smm_i  (acc_smm_i),
    .lock_i (lock_o),
    .bh_o   (bh_o),
    .ram_o  (ram_o)
  );
endmodule

// File: rtl/smbase_guard_chk.sv
module smbase_guard_chk
  import smbase_guard_pkg::*;
#(
  parameter int unsigned EXT_TSEG_MB = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              smbase_en_i,
  input logic              wr_en_i,
  input logic              wr_sel_i,
  input logic [TSEG_W-1:0] wr_data_i,
  input logic [SMB_W-1:0]  smbase_o,
  input logic [TSEG_W-1:0] tseg_mb_o,
  input logic              lock_o,
  input logic              bh_o,
  input logic              ram_o
);
  AST_UNQUERIED_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !wr_sel_i && smbase_en_i && smbase_o == '0 && wr_data_i[SMB_W-1:0] != SMB_QUERY)
    |=> (smbase_o == '0 && !lock_o)); // R2
  AST_QUERY_REPLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !wr_sel_i && smbase_en_i && smbase_o == '0 && wr_data_i[SMB_W-1:0] == SMB_QUERY)
    |=> (smbase_o == SMB_IN_RAM)); // R3
  AST_LOCK_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_o |=> lock_o); // R5
  AST_LOCK_VALUE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_o |-> (smbase_o == 8'h02)); // R4
  AST_FEAT_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!smbase_en_i && !lock_o) |=> !lock_o); // R6
  AST_FLAG_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(bh_o && ram_o)); // R7
  AST_FLAG_NEEDS_LOCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bh_o || ram_o) |-> $past(lock_o)); // R7
  AST_TSEG_QUERY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (EXT_TSEG_MB != 0 && wr_en_i && wr_sel_i && wr_data_i == TSEG_QUERY)
    |=> (tseg_mb_o == TSEG_W'(EXT_TSEG_MB))); // R8
  AST_SEL_ISOLATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_sel_i) |=> ($stable(smbase_o) && $stable(lock_o))); // R9
endmodule

bind smbase_guard smbase_guard_chk #(.EXT_TSEG_MB(EXT_TSEG_MB)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .smbase_en_i(smbase_en_i),
  .wr_en_i    (wr_en_i),
  .wr_sel_i   (wr_sel_i),
  .wr_data_i  (wr_data_i),
  .smbase_o   (smbase_o),
  .tseg_mb_o  (tseg_mb_o),
  .lock_o     (lock_o),
  .bh_o       (bh_o),
  .ram_o      (ram_o)
);

// File: tb/tb_smbase_guard.sv
`timescale 1ns/1ps
module tb_smbase_guard;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        smbase_en_i = 1'b1;
  logic        wr_en_i = 1'b0;
  logic        wr_sel_i = 1'b0;
  logic [15:0] wr_data_i = '0;
  logic        acc_valid_i = 1'b0;
  logic [31:0] acc_addr_i = '0;
  logic        acc_smm_i = 1'b0;
  logic [7:0]  smbase_o;
  logic [15:0] tseg_mb_o;
  logic        lock_o, bh_o, ram_o;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  typedef struct {
    string       tag;
    logic [7:0]  smb;
    logic [15:0] ts;
    logic        lk;
    logic        bh;
    logic        rm;
  } exp_t;

  exp_t exp_q[$];

  always #5 clk_i = ~clk_i;

  smbase_guard dut (
    .clk_i, .rst_ni, .smbase_en_i, .wr_en_i, .wr_sel_i, .wr_data_i,
    .acc_valid_i, .acc_addr_i, .acc_smm_i,
    .smbase_o, .tseg_mb_o, .lock_o, .bh_o, .ram_o
  );

  task automatic drive(input string tag, input logic wr, input logic sel,
                       input logic [15:0] d, input logic av, input logic [31:0] a,
                       input logic smm, input logic [7:0] es, input logic [15:0] et,
                       input logic el, input logic eb, input logic er);
    exp_t e;
    @(negedge clk_i);
    wr_en_i = wr; wr_sel_i = sel; wr_data_i = d;
    acc_valid_i = av; acc_addr_i = a; acc_smm_i = smm;
    e.tag = tag; e.smb = es; e.ts = et; e.lk = el; e.bh = eb; e.rm = er;
    exp_q.push_back(e);
  endtask

  task automatic do_reset(input logic feat);
    while (exp_q.size() != 0) @(posedge clk_i);
    @(negedge clk_i);
    wr_en_i = 1'b0; acc_valid_i = 1'b0;
    smbase_en_i = feat;
    rst_ni = 1'b0;
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
  endtask

  // monitor: one expected item per cycle, due one edge after its stimulus
  initial begin
    exp_t e;
    forever begin
      @(posedge clk_i);
      #1;
      if (exp_q.size() > 0) begin
        e = exp_q.pop_front();
        total++;
        if (smbase_o !== e.smb || tseg_mb_o !== e.ts || lock_o !== e.lk ||
            bh_o !== e.bh || ram_o !== e.rm) begin
          bad++;
          $display("FAIL %s: got smb=%h ts=%h lk=%b bh=%b ram=%b exp smb=%h ts=%h lk=%b bh=%b ram=%b",
                   e.tag, smbase_o, tseg_mb_o, lock_o, bh_o, ram_o,
                   e.smb, e.ts, e.lk, e.bh, e.rm);
        end
      end
    end
  end

  initial begin
    repeat (5000) @(posedge clk_i);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog: got hung run exp completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    do_reset(1'b1);
    drive("R1 reset",          0, 0, 16'h0000, 0, 32'h0, 0, 8'h00, 16'hFFFF, 0, 0, 0);
    drive("R7 unlocked hit",   0, 0, 16'h0000, 1, 32'h30000, 0, 8'h00, 16'hFFFF, 0, 0, 0);
    drive("R2 drop lockbit",   1, 0, 16'h0002, 0, 32'h0, 0, 8'h00, 16'hFFFF, 0, 0, 0);
    drive("R2 drop 55",        1, 0, 16'h0055, 0, 32'h0, 0, 8'h00, 16'hFFFF, 0, 0, 0);
    drive("R9 tseg plain",     1, 1, 16'h1234, 0, 32'h0, 0, 8'h00, 16'h1234, 0, 0, 0);
    drive("R8 tseg query",     1, 1, 16'hFFFF, 0, 32'h0, 0, 8'h00, 16'h0010, 0, 0, 0);
    drive("R3 query",          1, 0, 16'h00FF, 0, 32'h0, 0, 8'h01, 16'h0010, 0, 0, 0);
    drive("R3 mask 00",        1, 0, 16'h0000, 0, 32'h0, 0, 8'h01, 16'h0010, 0, 0, 0);
    drive("R3 mask FD",        1, 0, 16'h00FD, 0, 32'h0, 0, 8'h01, 16'h0010, 0, 0, 0);
    drive("R4 lock",           1, 0, 16'h0002, 0, 32'h0, 0, 8'h02, 16'h0010, 1, 0, 0);
    drive("R5 hold 00",        1, 0, 16'h0000, 0, 32'h0, 0, 8'h02, 16'h0010, 1, 0, 0);
    drive("R5 hold FF",        1, 0, 16'h00FF, 0, 32'h0, 0, 8'h02, 16'h0010, 1, 0, 0);
    drive("R9 tseg vs lock",   1, 1, 16'h0007, 0, 32'h0, 0, 8'h02, 16'h0007, 1, 0, 0);
    drive("R7 bh low edge",    0, 0, 16'h0000, 1, 32'h30000, 0, 8'h02, 16'h0007, 1, 1, 0);
    drive("R7 ram high edge",  0, 0, 16'h0000, 1, 32'h4FFFF, 1, 8'h02, 16'h0007, 1, 0, 1);
    drive("R7 past end",       0, 0, 16'h0000, 1, 32'h50000, 0, 8'h02, 16'h0007, 1, 0, 0);
    drive("R7 below base",     0, 0, 16'h0000, 1, 32'h2FFFF, 1, 8'h02, 16'h0007, 1, 0, 0);
    drive("R7 invalid",        0, 0, 16'h0000, 0, 32'h40000, 0, 8'h02, 16'h0007, 1, 0, 0);
    do_reset(1'b0);
    drive("R1 reset again",    0, 0, 16'h0000, 0, 32'h0, 0, 8'h00, 16'hFFFF, 0, 0, 0);
    drive("R6 raw FF",         1, 0, 16'h00FF, 0, 32'h0, 0, 8'hFF, 16'hFFFF, 0, 0, 0);
    drive("R6 raw 02",         1, 0, 16'h0002, 0, 32'h0, 0, 8'h02, 16'hFFFF, 0, 0, 0);
    drive("R6 no window",      0, 0, 16'h0000, 1, 32'h30000, 0, 8'h02, 16'hFFFF, 0, 0, 0);
    drive("R6 idle",           0, 0, 16'h0000, 0, 32'h0, 0, 8'h02, 16'hFFFF, 0, 0, 0);
    while (exp_q.size() != 0) @(posedge clk_i);
    @(negedge clk_i);
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule